// File: doc/BRIEF.md
# Instruction Fetch Front End with Branch Target Cache

The block is the front of an instruction pipeline. It generates fetch addresses, reads one fixed-width word per cycle from an instruction memory port, attaches prediction control bits in an early-decode stage, and parks each instruction in a one-entry output buffer. A consumer takes instructions through a valid/ready handshake. The four stages are address generation, memory fetch, early decode and output buffer. While the buffer is full and not taken, every stage holds.

A 16-entry direct-mapped branch target cache is consulted for the address currently being fetched. On a hit, the sequential address already prepared in the address stage is thrown away and the next fetch goes to the cached target. The stages ahead keep moving. On a miss, fetch steps to the next word. Execution writes or clears entries through an update port. It repairs a wrong prediction through a correction port, which empties the whole pipe and restarts fetch at the given address. A level input switches the cache off.

Top module: `fetch_front`

## Requirements
- R1: While reset is low, out_valid_o is 0 and mem_addr_o equals RESET_PC. After reset, the first delivered instruction is at RESET_PC.
- R2: When the fetched address misses, the instruction delivered after the one at address A is at A+4 (one 32-bit word).
- R3: When the fetched address A hits, the next delivered instruction is at the stored target. The instruction at A carries out_pred_o=1 and out_npc_o=target. A miss carries out_pred_o=0 and out_npc_o=A+4.
- R4: With btc_en_i low, no lookup hits and fetch stays sequential.
- R5: An entry is selected by address bits [5:2]. Its tag is all other address bits. A lookup hits only on a valid entry with an equal tag, so an address that shares the index but differs in the tag misses.
- R6: corr_valid_i flushes every stage. In the next cycle mem_addr_o equals corr_pc_i and out_valid_o is 0. The next delivered instruction is at corr_pc_i.
- R7: When a correction and a cache hit fall in the same cycle, the correction address is fetched next and the hit target is not.
- R8: While out_valid_o is 1 and out_ready_i is 0, the outputs hold still. No instruction is lost or repeated.
- R9: out_instr_o is the memory word returned for out_pc_o.
- R10: An update with upd_write_i=1 installs the pc/target pair. An update with upd_write_i=0 clears the entry at that index. Lookups see the change from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btc_en_i | input | 1 | Branch target cache enable |
| mem_addr_o | output | 32 | Instruction fetch address |
| mem_rdata_i | input | 32 | Word read at mem_addr_o, same cycle |
| upd_valid_i | input | 1 | Cache update strobe |
| upd_write_i | input | 1 | 1 installs the entry, 0 clears it |
| upd_pc_i | input | 32 | Branch address of the update |
| upd_target_i | input | 32 | Target address of the update |
| corr_valid_i | input | 1 | Mispredict correction strobe |
| corr_pc_i | input | 32 | Corrected fetch address |
| out_valid_o | output | 1 | Buffered instruction available |
| out_ready_i | input | 1 | Consumer accepts the instruction |
| out_pc_o | output | 32 | Address of the buffered instruction |
| out_instr_o | output | 32 | Buffered instruction word |
| out_pred_o | output | 1 | Instruction was predicted taken |
| out_npc_o | output | 32 | Predicted next address |

## Verification
A correction and a branch-target-cache redirect can arrive in the same cycle. To provoke this, the bench corrects to the address just below a cached branch. One cycle later, while mem_addr_o shows that branch, it raises a second correction to an unrelated address. The case is judged by mem_addr_o in the following cycle and by the first instruction delivered afterwards: both must be the correction address, not the cached target. Stalls are also mixed with redirects, using ready patterns during streams that pass through cached branches.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned IW    = 32;
  localparam int unsigned STEP  = IW / 8;
  localparam int unsigned OFS_W = $clog2(STEP);

  typedef logic [AW-1:0] addr_t;
  typedef logic [IW-1:0] word_t;

  // fetch -> early decode
  typedef struct packed {
    logic  vld;
    logic  pred;
    addr_t pc;
    addr_t tgt;
    word_t instr;
  } fd_t;

  // early decode -> buffer -> consumer
  typedef struct packed {
    logic  vld;
    logic  pred;
    addr_t pc;
    addr_t npc;
    word_t instr;
  } dq_t;
endpackage

// File: rtl/fe_btc.sv
`timescale 1ns/1ps
module fe_btc
  import fe_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  addr_t lk_pc_i,
  output logic  hit_o,
  output addr_t tgt_o,
  input  logic  upd_valid_i,
  input  logic  upd_write_i,
  input  addr_t upd_pc_i,
  input  addr_t upd_tgt_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = AW - IDX_W;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAG_W-1:0] tag_t;

  logic vld_q [ENTRIES];
  tag_t tag_q [ENTRIES];
  addr_t tgt_q [ENTRIES];

  function automatic idx_t idx_of(addr_t a);
    return a[OFS_W +: IDX_W];
  endfunction

  // tag keeps every bit outside the index field
  function automatic tag_t tag_of(addr_t a);
    return {a[AW-1:OFS_W+IDX_W], a[OFS_W-1:0]};
  endfunction

  idx_t lk_idx, up_idx;
  assign lk_idx = idx_of(lk_pc_i);
  assign up_idx = idx_of(upd_pc_i);

  assign hit_o = en_i && vld_q[lk_idx] && (tag_q[lk_idx] == tag_of(lk_pc_i));
  assign tgt_o = tgt_q[lk_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (upd_valid_i) begin
      vld_q[up_idx] <= upd_write_i;
      tag_q[up_idx] <= tag_of(upd_pc_i);
      tgt_q[up_idx] <= upd_tgt_i;
    end
  end

  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_write_i |=> vld_q[$past(up_idx)] && (tgt_q[$past(up_idx)] == $past(upd_tgt_i)));

  p_clear_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_write_i |=> !vld_q[$past(up_idx)]);
endmodule

// File: rtl/fe_early_decode.sv
`timescale 1ns/1ps
module fe_early_decode
  import fe_pkg::*;
(
  input  fd_t in_i,
  output dq_t out_o
);
  always_comb begin
    out_o.vld   = in_i.vld;
    out_o.pred  = in_i.pred;
    out_o.pc    = in_i.pc;
    out_o.instr = in_i.instr;
    out_o.npc   = in_i.pred ? in_i.tgt : in_i.pc + addr_t'(STEP);
  end
endmodule

// File: rtl/fe_out_buf.sv
`timescale 1ns/1ps
module fe_out_buf
  import fe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  dq_t  in_i,
  input  logic ready_i,
  output dq_t  q_o,
  output logic stall_o
);
  dq_t q;

  assign stall_o = q.vld && !ready_i;
  assign q_o     = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (flush_i)  q.vld <= 1'b0;
    else if (!stall_o) q <= in_i;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q.vld && !ready_i && !flush_i |=> q.vld && $stable(q));
endmodule

// File: rtl/fetch_front.sv
`timescale 1ns/1ps
module fetch_front
  import fe_pkg::*;
#(
  parameter int unsigned  BTC_ENTRIES = 16,
  parameter logic [31:0]  RESET_PC    = 32'h0000_1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        btc_en_i,
  output logic [31:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        upd_valid_i,
  input  logic        upd_write_i,
  input  logic [31:0] upd_pc_i,
  input  logic [31:0] upd_target_i,
  input  logic        corr_valid_i,
  input  logic [31:0] corr_pc_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [31:0] out_pc_o,
  output logic [31:0] out_instr_o,
  output logic        out_pred_o,
  output logic [31:0] out_npc_o
);
  localparam addr_t STEP_A = addr_t'(STEP);

  addr_t gen_pc_q;   // address stage
  addr_t fet_pc_q;   // fetch stage
  fd_t   dec_q;      // early decode stage input
  dq_t   dec_out, buf_q;
  logic  stall, hit;
  addr_t hit_tgt;

  fe_btc #(.ENTRIES(BTC_ENTRIES)) u_btc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (btc_en_i),
    .lk_pc_i     (fet_pc_q),
    .hit_o       (hit),
    .tgt_o       (hit_tgt),
    .upd_valid_i (upd_valid_i),
    .upd_write_i (upd_write_i),
    .upd_pc_i    (upd_pc_i),
    .upd_tgt_i   (upd_target_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fet_pc_q <= RESET_PC;
      gen_pc_q <= RESET_PC + STEP_A;
      dec_q    <= '0;
    end else if (corr_valid_i) begin
      fet_pc_q  <= corr_pc_i;
      gen_pc_q  <= corr_pc_i + STEP_A;
      dec_q.vld <= 1'b0;
    end else if (!stall) begin
      dec_q <= '{vld: 1'b1, pred: hit, pc: fet_pc_q, tgt: hit_tgt, instr: mem_rdata_i};
      if (hit) begin
        // sequential address in the address stage is squashed
        fet_pc_q <= hit_tgt;
        gen_pc_q <= hit_tgt + STEP_A;
      end else begin
        fet_pc_q <= gen_pc_q;
        gen_pc_q <= gen_pc_q + STEP_A;
      end
    end
  end

  fe_early_decode u_dec (
    .in_i  (dec_q),
    .out_o (dec_out)
  );

  fe_out_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (corr_valid_i),
    .in_i    (dec_out),
    .ready_i (out_ready_i),
    .q_o     (buf_q),
    .stall_o (stall)
  );

  assign mem_addr_o  = fet_pc_q;
  assign out_valid_o = buf_q.vld;
  assign out_pc_o    = buf_q.pc;
  assign out_instr_o = buf_q.instr;
  assign out_pred_o  = buf_q.pred;
  assign out_npc_o   = buf_q.npc;

  p_corr_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_i |=> (mem_addr_o == $past(corr_pc_i)) && !out_valid_o);

  p_corr_beats_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_i && hit |=> mem_addr_o != $past(hit_tgt) || $past(hit_tgt) == $past(corr_pc_i));

  p_hit_redirect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !corr_valid_i && !stall |=> mem_addr_o == $past(hit_tgt));

  p_seq_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !btc_en_i && !corr_valid_i && !stall |=> mem_addr_o == $past(mem_addr_o) + STEP_A);

  p_stall_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !corr_valid_i |=> $stable(mem_addr_o));
endmodule

// File: tb/fetch_front_bench.sv
`timescale 1ns/1ps
module fetch_front_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [31:0] maddr, mdata;
  logic        upd_v = 1'b0, upd_w = 1'b0;
  logic [31:0] upd_pc = '0, upd_tg = '0;
  logic        corr_v = 1'b0;
  logic [31:0] corr_pc = '0;
  logic        ovalid, rdy = 1'b0, opred;
  logic [31:0] opc, oinstr, onpc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  assign mdata = mem_word(maddr);

  fetch_front #(.RESET_PC(RST_PC)) u_fetch_front (
    .clk_i(clk), .rst_ni(rst_n), .btc_en_i(en),
    .mem_addr_o(maddr), .mem_rdata_i(mdata),
    .upd_valid_i(upd_v), .upd_write_i(upd_w), .upd_pc_i(upd_pc), .upd_target_i(upd_tg),
    .corr_valid_i(corr_v), .corr_pc_i(corr_pc),
    .out_valid_o(ovalid), .out_ready_i(rdy), .out_pc_o(opc),
    .out_instr_o(oinstr), .out_pred_o(opred), .out_npc_o(onpc)
  );

  // bench model of the cache: index = bits [5:2], tag = the other bits
  logic        m_vld [16];
  logic [31:0] m_pc  [16];
  logic [31:0] m_tgt [16];

  function automatic logic m_hit(logic [31:0] a, logic e);
    return e && m_vld[a[5:2]] && (m_pc[a[5:2]][31:6] == a[31:6]) && (m_pc[a[5:2]][1:0] == a[1:0]);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tg, input logic wr);
    @(negedge clk);
    upd_v = 1'b1; upd_w = wr; upd_pc = pc; upd_tg = tg;
    @(negedge clk);
    upd_v = 1'b0;
    m_vld[pc[5:2]] = wr; m_pc[pc[5:2]] = pc; m_tgt[pc[5:2]] = tg;
  endtask

  task automatic correct(input logic [31:0] pc);
    @(negedge clk);
    corr_v = 1'b1; corr_pc = pc;
    @(negedge clk);
    corr_v = 1'b0;
  endtask

  // take n instructions, ready driven from a rotating mask, compare with model
  task automatic consume(input string tag, input logic [7:0] mask, input int n,
                         input logic [31:0] start, input logic e);
    logic [31:0] exp_pc = start;
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 400) begin
      @(negedge clk);
      rdy = mask[cyc%8];
      if (ovalid && rdy) begin
        logic h = m_hit(exp_pc, e);
        logic [31:0] nx = h ? m_tgt[exp_pc[5:2]] : exp_pc + 32'd4;
        chk({tag, " pc"}, 64'(opc), 64'(exp_pc));
        chk({tag, " R9 instr/pred/npc"}, {oinstr, opred, onpc[30:0]},
            {mem_word(exp_pc), h, nx[30:0]});
        exp_pc = nx;
        got++;
      end
      cyc++;
    end
    if (got < n) chk({tag, " R8 delivered count"}, 64'(got), 64'(n));
    rdy = 1'b1;
  endtask

  // {start pc, cache enable, ready mask}
  localparam logic [40:0] VECS [6] = '{
    {32'h0000_00F8, 1'b1, 8'hFF},
    {32'h0000_00F8, 1'b1, 8'hA6},
    {32'h0000_00F8, 1'b0, 8'hFF},
    {32'h0000_0138, 1'b1, 8'hFF},
    {32'h0000_0400, 1'b1, 8'h33},
    {32'h0000_01FC, 1'b1, 8'h81}
  };
  localparam string VTAG [6] = '{"R3", "R8", "R4", "R5", "R2", "R8"};

  initial begin
    for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0; end
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", 64'(ovalid), 64'd0);
    chk("R1 addr in reset", 64'(maddr), 64'(RST_PC));
    rst_n = 1'b1;
    consume("R1", 8'hFF, 3, RST_PC, 1'b1);

    update(32'h0000_0100, 32'h0000_0200, 1'b1);
    update(32'h0000_0208, 32'h0000_0100, 1'b1);
    update(32'h0000_040C, 32'h0000_0400, 1'b1);

    for (int v = 0; v < 6; v++) begin
      en = VECS[v][8];
      correct(VECS[v][40:9]);
      consume(VTAG[v], VECS[v][7:0], 8, VECS[v][40:9], VECS[v][8]);
    end
    en = 1'b1;

    // R6: correction flushes and restarts next cycle
    rdy = 1'b0;
    repeat (3) @(negedge clk);
    corr_v = 1'b1; corr_pc = 32'h0000_0500;
    @(negedge clk);
    corr_v = 1'b0;
    chk("R6 addr", 64'(maddr), 64'h500);
    chk("R6 flushed", 64'(ovalid), 64'd0);
    consume("R6", 8'hFF, 2, 32'h0000_0500, 1'b1);

    // R7: correction in the cycle the branch at 0x100 hits
    rdy = 1'b1;
    correct(32'h0000_00FC);
    chk("R7 setup", 64'(maddr), 64'hFC);
    @(negedge clk);
    chk("R7 branch in fetch", 64'(maddr), 64'h100);
    corr_v = 1'b1; corr_pc = 32'h0000_0300;
    @(negedge clk);
    corr_v = 1'b0;
    chk("R7 addr", 64'(maddr), 64'h300);
    chk("R7 flushed", 64'(ovalid), 64'd0);
    consume("R7", 8'hFF, 2, 32'h0000_0300, 1'b1);

    // R10: clear an entry, then install one at a fresh index
    update(32'h0000_0100, 32'h0, 1'b0);
    update(32'h0000_0104, 32'h0000_0700, 1'b1);
    correct(32'h0000_00F8);
    consume("R10", 8'hFF, 6, 32'h0000_00F8, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule